// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management frames on the MDC/MDIO pins for a host processor. The host programs a PHY address and a register number into a small word-addressed register bank. Storing a 16-bit value into the write-data register sends a write frame to that PHY register. A read frame is started by taking the read bit of the command register from 0 to 1. The received 16 bits appear in the read-data register once the frame has ended.

MDC is derived from the system clock through a programmable divider. MDIO changes on the falling edge of MDC and is sampled on the rising edge. The block drives MDIO only while it owns the line. The host polls an indication register, which holds a busy flag and a separate flag that marks read data as stale. A self-clearing abort bit in the configuration register stops any frame at once.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the indication register (byte offset 0x14) reads 0, the configuration register (offset 0x00) reads the divider value 7 in its low bits, and MDC and the MDIO output enable are low.
- R2: The address register (offset 0x08) keeps the PHY address in bits 12:8 and the register number in bits 4:0. Both fields are sent MSB first, PHY address first.
- R3: Writing the write-data register (offset 0x0C) while idle starts a frame. The frame is 32 ones, then 01, then opcode 01, the PHY address, the register number, turnaround 10 and the 16 data bits MSB first. Every bit of it is driven.
- R4: A read frame starts only when a write to the command register (offset 0x04) takes bit 0 from 0 to 1. Writing 1 while the stored bit is already 1 starts nothing.
- R5: A read frame sends opcode 10 and releases the output enable from the first turnaround bit to the end of the frame. The 16 bits sampled on the last 16 rising MDC edges then appear in bits 15:0 of the read-data register (offset 0x10), MSB first, and its upper bits read 0.
- R6: Indication bit 0 (busy) stays set for exactly 128×(divider+1) system clock cycles from the cycle that starts a frame.
- R7: Indication bit 2 (stale) is set when a read starts, is never set without busy, and clears in the same cycle that busy clears, together with the update of the read data.
- R8: The MDC period is 2×(divider+1) system clocks. MDC is low whenever no frame is running. The MDIO output changes only at a falling MDC edge.
- R9: A write-data store or a read edge that arrives while busy has no effect. The running frame is unchanged, the write-data register keeps its value, and no further frame follows.
- R10: Writing the configuration register with bit 31 set aborts the current frame. In the next cycle busy, stale, MDC and the output enable are low. Bit 31 reads back as 0, and the divider takes the written low bits.
- R11: When a frame ends, the output enable drops to 0 and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 5 | Byte address of the register |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data of the register at host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or divider shows at the ports within one frame. The busy time seen by the host is off by whole MDC periods, or the captured pin sequence is shifted by a bit against the expected frame. A stale-flag or capture fault is visible in the first read after the fault, because the read data or indication register disagrees with the bits the PHY model drove. Aborts and writes made while busy are checked in the next few cycles: the pins must fall idle, or the running frame must stay bit-exact.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_W   = 4,
  parameter int DIV_RST = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [4:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam logic [2:0] SEL_CFG = 3'd0;
  localparam logic [2:0] SEL_CMD = 3'd1;
  localparam logic [2:0] SEL_ADR = 3'd2;
  localparam logic [2:0] SEL_WDT = 3'd3;
  localparam logic [2:0] SEL_RDT = 3'd4;
  localparam logic [2:0] SEL_IND = 3'd5;
  localparam logic [5:0] LAST_BIT = 6'd63;
  localparam logic [5:0] TA_POS   = 6'd46;
  localparam logic [5:0] DATA_POS = 6'd48;

  logic [DIV_W-1:0] div_q, half_q;
  logic             rd_cmd_q, busy_q, stale_q, op_rd_q, mdc_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      wdat_q, rdat_q, shin_q;
  logic [5:0]       bit_q;
  logic [63:0]      frame_q;

  wire [2:0] sel      = host_addr[4:2];
  wire       wr_cfg   = host_we && (sel == SEL_CFG);
  wire       wr_cmd   = host_we && (sel == SEL_CMD);
  wire       wr_adr   = host_we && (sel == SEL_ADR);
  wire       wr_wdt   = host_we && (sel == SEL_WDT);
  wire       abort    = wr_cfg && host_wdata[31];
  wire       start_wr = wr_wdt && !busy_q;
  wire       start_rd = wr_cmd && host_wdata[0] && !rd_cmd_q && !busy_q;
  wire       half_tick = busy_q && (half_q >= div_q);
  wire       rise     = half_tick && !mdc_q;
  wire       fall     = half_tick && mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_RST);
      half_q   <= '0;
      rd_cmd_q <= 1'b0;
      busy_q   <= 1'b0;
      stale_q  <= 1'b0;
      op_rd_q  <= 1'b0;
      mdc_q    <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      wdat_q   <= '0;
      rdat_q   <= '0;
      shin_q   <= '0;
      bit_q    <= '0;
      frame_q  <= '0;
    end else begin
      if (wr_cfg) div_q <= host_wdata[DIV_W-1:0];
      if (wr_cmd) rd_cmd_q <= host_wdata[0];
      if (wr_adr) begin
        phy_q <= host_wdata[12:8];
        reg_q <= host_wdata[4:0];
      end
      if (start_wr) wdat_q <= host_wdata[15:0];
      if (abort) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
        mdc_q   <= 1'b0;
        half_q  <= '0;
        bit_q   <= '0;
      end else if (start_wr || start_rd) begin
        busy_q  <= 1'b1;
        op_rd_q <= start_rd;
        stale_q <= start_rd;
        mdc_q   <= 1'b0;
        half_q  <= '0;
        bit_q   <= '0;
        frame_q <= start_rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, phy_q, reg_q, 2'b11, 16'hFFFF}
                            : {32'hFFFF_FFFF, 2'b01, 2'b01, phy_q, reg_q, 2'b10, host_wdata[15:0]};
      end else if (busy_q) begin
        if (half_tick) begin
          half_q <= '0;
          mdc_q  <= ~mdc_q;
          if (rise && op_rd_q && (bit_q >= DATA_POS)) shin_q <= {shin_q[14:0], mdio_i};
          if (fall) begin
            if (bit_q == LAST_BIT) begin
              busy_q <= 1'b0;
              if (op_rd_q) begin
                stale_q <= 1'b0;
                rdat_q  <= shin_q;
              end
            end else begin
              bit_q <= bit_q + 6'd1;
            end
          end
        end else begin
          half_q <= half_q + DIV_W'(1);
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = busy_q && frame_q[LAST_BIT - bit_q];
  assign mdio_oe = busy_q && !(op_rd_q && (bit_q >= TA_POS));

  always_comb begin
    case (sel)
      SEL_CFG: host_rdata = 32'(div_q);
      SEL_CMD: host_rdata = {31'b0, rd_cmd_q};
      SEL_ADR: host_rdata = {19'b0, phy_q, 3'b0, reg_q};
      SEL_WDT: host_rdata = {16'b0, wdat_q};
      SEL_RDT: host_rdata = {16'b0, rdat_q};
      SEL_IND: host_rdata = {29'b0, stale_q, 1'b0, busy_q};
      default: host_rdata = 32'b0;
    endcase
  end

  AST_STALE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) stale_q |-> busy_q); // R7
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !mdc_q); // R8
  AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$fell(mdc_q)) |-> $stable(mdio_o)); // R8
  AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (!mdc_q && bit_q == 6'd0 && mdio_o && mdio_oe)); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_wdt) |=> $stable(wdat_q)); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && !stale_q && !mdc_q && !mdio_oe)); // R10

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0, mdio_i = 1'b1;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, bitpos = 0;
  bit done = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_data = '0;
  time t0, t1;

  always @(posedge mdc) begin
    #1;
    if (bitpos < 64) begin
      cap_o[63-bitpos]  = mdio_o;
      cap_oe[63-bitpos] = mdio_oe;
    end
    if (bitpos == 0) t0 = $time;
    if (bitpos == 1) t1 = $time;
    bitpos++;
  end

  always @(negedge mdc) begin
    #1;
    if (bitpos >= 48 && bitpos < 64) mdio_i = phy_data[63-bitpos];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int cycles, output bit stale_all);
    logic [31:0] v;
    cycles = 0; stale_all = 1;
    forever begin
      rd(5'h14, v);
      if (!v[0]) break;
      if (!v[2]) stale_all = 0;
      cycles++;
      if (cycles > 20000) begin chk("R6 hang", 64'(cycles), 0); break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_oe(bit is_rd);
    return is_rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic start(bit is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] d, int dv);
    wr(5'h00, 32'(dv));
    wr(5'h08, {19'b0, p, 3'b0, r});
    phy_data = d; bitpos = 0; mdio_i = 1'b1;
    if (is_rd) begin wr(5'h04, 0); wr(5'h04, 1); end
    else wr(5'h0C, {16'b0, d});
  endtask

  task automatic run_frame(bit is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] d, int dv);
    int cyc; bit st; logic [31:0] v;
    logic [63:0] m;
    start(is_rd, p, r, d, dv);
    wait_idle(cyc, st);
    m = exp_oe(is_rd);
    chk("R6 busy cycles", 64'(cyc), 64'(128*(dv+1)));
    chk(is_rd ? "R5 oe pattern" : "R3 oe pattern", cap_oe, m);
    chk(is_rd ? "R5 frame bits" : "R3 frame bits", cap_o & m, exp_frame(is_rd, p, r, d) & m);
    chk("R8 mdc period", 64'((t1 - t0) / 4), 64'(2*(dv+1)));
    chk("R11 idle pins", {62'b0, mdio_oe, mdc}, 64'b0);
    rd(5'h08, v);
    chk("R2 address fields", 64'(v), 64'({p, 3'b0, r}));
    if (is_rd) begin
      chk("R7 stale during read", 64'(st), 64'd1);
      rd(5'h14, v);
      chk("R7 stale cleared", 64'(v), 64'd0);
      rd(5'h10, v);
      chk("R5 read data", 64'(v), 64'(d));
    end
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc; bit st;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h14, v); chk("R1 indication reset", 64'(v), 64'd0);
    rd(5'h00, v); chk("R1 divider reset", 64'(v), 64'd7);
    chk("R1 pins reset", {62'b0, mdio_oe, mdc}, 64'b0);

    run_frame(0, 5'h15, 5'h0A, 16'hA5C3, 1);
    run_frame(1, 5'h01, 5'h1F, 16'h8001, 0);
    run_frame(1, 5'h1F, 5'h00, 16'h0000, 2);
    run_frame(0, 5'h00, 5'h1F, 16'hFFFF, 7);

    start(0, 5'h03, 5'h04, 16'h1234, 1);
    repeat (20) @(negedge clk);
    wr(5'h0C, 32'h0000_BEEF);
    wr(5'h04, 0);
    wr(5'h04, 1);
    wait_idle(cyc, st);
    chk("R9 frame untouched", cap_o, exp_frame(0, 5'h03, 5'h04, 16'h1234));
    rd(5'h0C, v); chk("R9 write data kept", 64'(v), 64'h1234);
    repeat (5) @(negedge clk);
    rd(5'h14, v); chk("R9 no extra frame", 64'(v), 64'd0);
    wr(5'h04, 1);
    repeat (3) @(negedge clk);
    rd(5'h14, v); chk("R4 no edge no read", 64'(v), 64'd0);

    start(1, 5'h07, 5'h02, 16'h5A5A, 3);
    repeat (100) @(negedge clk);
    wr(5'h00, 32'h8000_0002);
    rd(5'h14, v); chk("R10 abort flags", 64'(v), 64'd0);
    chk("R10 abort pins", {62'b0, mdio_oe, mdc}, 64'b0);
    rd(5'h00, v); chk("R10 divider readback", 64'(v), 64'd2);

    for (int k = 0; k < 10; k++) begin
      bit is_rd = 1'($urandom_range(0, 1));
      run_frame(is_rd, 5'($urandom), 5'($urandom), 16'($urandom), int'($urandom_range(0, 3)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule